// File: doc/BRIEF.md
# Slave FIFO Read Master with Message Framing

This block sits on the FPGA side of a synchronous 16-bit slave-FIFO bus that leads to an external USB bridge. It drains the bridge's host-to-device FIFO: it watches the bridge's active-low empty flag and drives the active-low output-enable and read strobes. Each word it pulls off the bus is handed to a small framer. The framer turns the raw word stream into delimited application messages.

The bridge fills its FIFO one whole packet at a time. A reader that is faster than the USB link therefore sees the FIFO run dry in the middle of a message. Zero-length packets leave no trace on the flags. The empty flag thus says only when a word may be read, and never where a message ends. Message boundaries come from the data itself. The first word of every message holds its payload length in bytes. The framer counts payload bytes against that length, marks the first and last payload words, flags a final word that carries only one valid byte, and reports a zero length with a one-cycle error pulse. A sink-side ready input throttles reading without giving up the bus.

Top module: `slvfifo_rd_master`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `bus_oe_n` and `bus_rd_n` are high and `msg_valid` and `msg_len_err` are low.
- R2: If `bus_empty_n` is low at a rising edge, both `bus_oe_n` and `bus_rd_n` are high for the following cycle.
- R3: If `bus_empty_n` and `sink_ready` are both high at a rising edge, `bus_oe_n` and `bus_rd_n` are both low for the following cycle, and `bus_rd_n` is never low while `bus_oe_n` is high.
- R4: If `sink_ready` is low at a rising edge, `bus_rd_n` is high for the following cycle while `bus_oe_n` still follows the empty flag, so no word leaves the bridge. At most one word strobed before that edge can still be delivered.
- R5: A bus word is taken only at a rising edge where `bus_rd_n` is low and `bus_empty_n` is high. Its result appears on the message outputs in the cycle after that edge.
- R6: The first word taken after reset, or after the end of a message or a length error, is an unsigned byte count and is not delivered. The first payload word that follows is delivered with `msg_sop` high.
- R7: A message of L bytes yields exactly ceil(L/2) delivered words. `msg_eop` is high on the word where the byte count reaches L, and only on that word.
- R8: `msg_lo_only` is high on the last word of a message with odd L, where only bits 7:0 are valid. It is low on every other word.
- R9: A length word of zero gives a one-cycle `msg_len_err` pulse, delivers no word, and the next word taken is read as a new length.
- R10: An empty FIFO in the middle of a message neither ends the message nor loses its place. Reading resumes with the next payload word once the flag clears.
- R11: Delivered payload words appear on `msg_data` unchanged and in bus order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_empty_n | input | 1 | Bridge FIFO empty flag, low = empty |
| bus_data | input | 16 | Bridge FIFO head word |
| bus_oe_n | output | 1 | Bus output enable to the bridge, active low |
| bus_rd_n | output | 1 | Read strobe to the bridge, active low |
| sink_ready | input | 1 | Downstream may accept words; low stalls reading |
| msg_valid | output | 1 | A payload word is present this cycle |
| msg_data | output | 16 | Payload word |
| msg_sop | output | 1 | First payload word of a message |
| msg_eop | output | 1 | Last payload word of a message |
| msg_lo_only | output | 1 | Only the low byte of this last word is valid |
| msg_len_err | output | 1 | One-cycle pulse: a zero length word was read |

## Verification
The properties assume that the bridge shows its head word on `bus_data` whenever `bus_empty_n` is high, and moves to the next word only at an edge where the strobe was low. They also assume that the empty flag falls only when that pop drains the last committed word. The bench's FIFO model keeps to this. It pops exactly on edges where the strobe is low and a word is present, and it commits whole multi-word chunks on falling edges. It leaves idle gaps between chunks, so the flag drops inside messages and not only between them. `sink_ready` is toggled only on falling edges.

// File: rtl/srm_pkg.sv
package srm_pkg;

    localparam int BUS_W          = 16;
    localparam int BYTES_PER_WORD = BUS_W / 8;

    typedef logic [BUS_W-1:0] word_t;

    typedef enum logic {
        ST_LEN,
        ST_BODY
    } frm_state_e;

    typedef struct packed {
        logic  valid;
        logic  sop;
        logic  eop;
        logic  lo_only;
        word_t data;
    } beat_t;

    // True when the remaining byte count fits in the current word.
    function automatic logic is_last_word(input word_t remaining);
        return remaining <= word_t'(BYTES_PER_WORD);
    endfunction

    // True when the last word is only partly filled.
    function automatic logic is_partial_word(input word_t remaining);
        return remaining < word_t'(BYTES_PER_WORD);
    endfunction

endpackage

// File: rtl/srm_strobe_ctl.sv
module srm_strobe_ctl (
    input  logic clk,
    input  logic rst,
    input  logic empty_n,
    input  logic sink_ready,
    output logic oe_n,
    output logic rd_n,
    output logic take
);

    logic oe_n_q;
    logic rd_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_n_q <= 1'b1;
            rd_n_q <= 1'b1;
        end else begin
            oe_n_q <= ~empty_n;
            rd_n_q <= ~(empty_n & sink_ready);
        end
    end

    assign oe_n = oe_n_q;
    assign rd_n = rd_n_q;
    // A word moves only when the strobe was out and the bridge had data.
    assign take = ~rd_n_q & empty_n;

endmodule

// File: rtl/srm_framer.sv
module srm_framer
    import srm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take,
    input  word_t word_in,
    output beat_t beat_o,
    output logic  len_err_o
);

    frm_state_e state_q;
    word_t      remain_q;
    logic       first_q;
    beat_t      beat_q;
    logic       err_q;

    logic last_w;
    logic part_w;

    assign last_w = is_last_word(remain_q);
    assign part_w = is_partial_word(remain_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_LEN;
            remain_q <= '0;
            first_q  <= 1'b0;
            beat_q   <= '0;
            err_q    <= 1'b0;
        end else begin
            beat_q <= '0;
            err_q  <= 1'b0;
            if (take) begin
                unique case (state_q)
                    ST_LEN: begin
                        if (word_in == '0) begin
                            err_q <= 1'b1;
                        end else begin
                            remain_q <= word_in;
                            first_q  <= 1'b1;
                            state_q  <= ST_BODY;
                        end
                    end
                    ST_BODY: begin
                        beat_q.valid   <= 1'b1;
                        beat_q.sop     <= first_q;
                        beat_q.eop     <= last_w;
                        beat_q.lo_only <= last_w & part_w;
                        beat_q.data    <= word_in;
                        first_q        <= 1'b0;
                        if (last_w) begin
                            state_q <= ST_LEN;
                        end else begin
                            remain_q <= remain_q - word_t'(BYTES_PER_WORD);
                        end
                    end
                    default: state_q <= ST_LEN;
                endcase
            end
        end
    end

    assign beat_o    = beat_q;
    assign len_err_o = err_q;

endmodule

// File: rtl/slvfifo_rd_master.sv
module slvfifo_rd_master
    import srm_pkg::*;
#(
    parameter int DATA_W = BUS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_empty_n,
    input  logic [DATA_W-1:0] bus_data,
    output logic              bus_oe_n,
    output logic              bus_rd_n,
    input  logic              sink_ready,
    output logic              msg_valid,
    output logic [DATA_W-1:0] msg_data,
    output logic              msg_sop,
    output logic              msg_eop,
    output logic              msg_lo_only,
    output logic              msg_len_err
);

    logic  take_w;
    beat_t beat_w;

    srm_strobe_ctl u_strobe (
        .clk        (clk),
        .rst        (rst),
        .empty_n    (bus_empty_n),
        .sink_ready (sink_ready),
        .oe_n       (bus_oe_n),
        .rd_n       (bus_rd_n),
        .take       (take_w)
    );

    srm_framer u_framer (
        .clk       (clk),
        .rst       (rst),
        .take      (take_w),
        .word_in   (word_t'(bus_data)),
        .beat_o    (beat_w),
        .len_err_o (msg_len_err)
    );

    assign msg_valid   = beat_w.valid;
    assign msg_data    = DATA_W'(beat_w.data);
    assign msg_sop     = beat_w.sop;
    assign msg_eop     = beat_w.eop;
    assign msg_lo_only = beat_w.lo_only;

endmodule

// File: rtl/srm_checker.sv
module srm_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_empty_n,
    input logic [DATA_W-1:0] bus_data,
    input logic              bus_oe_n,
    input logic              bus_rd_n,
    input logic              sink_ready,
    input logic              msg_valid,
    input logic [DATA_W-1:0] msg_data,
    input logic              msg_sop,
    input logic              msg_eop,
    input logic              msg_lo_only,
    input logic              msg_len_err
);

    logic in_msg;

    always_ff @(posedge clk) begin
        if (rst)            in_msg <= 1'b0;
        else if (msg_valid) in_msg <= ~msg_eop;
    end

    p_rd_needs_oe_r3: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_n |-> !bus_oe_n);

    p_release_on_empty_r2: assert property (@(posedge clk) disable iff (rst)
        !bus_empty_n |=> (bus_rd_n && bus_oe_n));

    p_start_together_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_empty_n && sink_ready) |=> (!bus_rd_n && !bus_oe_n));

    p_ready_stall_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_empty_n && !sink_ready) |=> (bus_rd_n && !bus_oe_n));

    p_beat_from_take_r5: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> $past(!bus_rd_n && bus_empty_n));

    p_sop_fresh_r6: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_sop) |-> !in_msg);

    p_body_inside_r7: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_sop) |-> in_msg);

    p_lo_only_last_r8: assert property (@(posedge clk) disable iff (rst)
        msg_lo_only |-> (msg_valid && msg_eop));

    p_err_no_beat_r9: assert property (@(posedge clk) disable iff (rst)
        msg_len_err |-> (!msg_valid && !in_msg));

    p_err_from_take_r9: assert property (@(posedge clk) disable iff (rst)
        msg_len_err |-> $past(!bus_rd_n && bus_empty_n));

endmodule

bind slvfifo_rd_master srm_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_empty_n (bus_empty_n),
    .bus_data    (bus_data),
    .bus_oe_n    (bus_oe_n),
    .bus_rd_n    (bus_rd_n),
    .sink_ready  (sink_ready),
    .msg_valid   (msg_valid),
    .msg_data    (msg_data),
    .msg_sop     (msg_sop),
    .msg_eop     (msg_eop),
    .msg_lo_only (msg_lo_only),
    .msg_len_err (msg_len_err)
);

// File: tb/slvfifo_rd_master_tb_top.sv
module slvfifo_rd_master_tb_top;

    localparam int DW     = 16;
    localparam int N_MSG  = 9;
    localparam int MEM_N  = 1024;
    localparam int EXP_N  = 256;
    localparam int GAP    = 6;
    // Each row: length in bytes, words per committed chunk, ready toggling
    localparam int MSG_TAB [0:N_MSG-1][0:2] = '{
        '{5, 2, 0}, '{4, 1, 0}, '{1, 3, 0}, '{0, 1, 0}, '{7, 1, 1},
        '{8, 9, 0}, '{0, 2, 0}, '{2, 1, 1}, '{3, 2, 0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_empty_n;
    logic [DW-1:0] bus_data;
    logic          bus_oe_n, bus_rd_n;
    logic          sink_ready = 1'b1;
    logic          msg_valid, msg_sop, msg_eop, msg_lo_only, msg_len_err;
    logic [DW-1:0] msg_data;

    logic [DW-1:0] mem [0:MEM_N-1];
    int rd_ptr = 0;
    int wr_ptr = 0;
    int stg    = 0;

    int          exp_kind [0:EXP_N-1];
    logic [18:0] exp_beat [0:EXP_N-1];
    int exp_wr = 0;
    int exp_rd = 0;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    logic prev_e = 1'b0, prev_r = 1'b0, prev_live = 1'b0;

    always #5 clk = ~clk;

    assign bus_empty_n = (rd_ptr != wr_ptr);
    assign bus_data    = mem[rd_ptr % MEM_N];

    slvfifo_rd_master #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .bus_empty_n(bus_empty_n), .bus_data(bus_data),
        .bus_oe_n(bus_oe_n), .bus_rd_n(bus_rd_n), .sink_ready(sink_ready),
        .msg_valid(msg_valid), .msg_data(msg_data), .msg_sop(msg_sop),
        .msg_eop(msg_eop), .msg_lo_only(msg_lo_only), .msg_len_err(msg_len_err)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Bridge model: pop on an edge with the strobe low and data present.
    always @(posedge clk) begin
        prev_e    <= bus_empty_n;
        prev_r    <= sink_ready;
        prev_live <= !rst;
        if (!bus_rd_n && (rd_ptr != wr_ptr)) rd_ptr <= rd_ptr + 1;
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            chk(1'b0, "watchdog", cyc, 0);
            report();
        end
    end

    // Monitor, away from the active edge.
    always @(negedge clk) begin
        if (prev_live && !rst) begin
            chk(bus_oe_n == !prev_e, "R2/R3 oe", bus_oe_n, !prev_e);
            chk(bus_rd_n == !(prev_e && prev_r), "R3/R4 rd", bus_rd_n, !(prev_e && prev_r));
        end
        if (!rst && msg_valid) begin
            if (exp_rd < exp_wr && exp_kind[exp_rd] == 0)
                chk({msg_sop, msg_eop, msg_lo_only, msg_data} == exp_beat[exp_rd],
                    "R6/R7/R8/R10/R11 beat", {msg_sop, msg_eop, msg_lo_only, msg_data},
                    exp_beat[exp_rd]);
            else
                chk(1'b0, "R7/R9 unexpected beat", msg_data, exp_rd);
            exp_rd++;
        end
        if (!rst && msg_len_err) begin
            chk(exp_rd < exp_wr && exp_kind[exp_rd] == 1, "R9 len_err", 1,
                (exp_rd < exp_wr) ? exp_kind[exp_rd] : -1);
            exp_rd++;
        end
    end

    // Stage one message and its expected results, then commit it in chunks.
    task automatic send_msg(input int idx, input int len, input int chunk, input int rmode);
        int nw;
        nw = (len + 1) / 2;
        mem[stg % MEM_N] = DW'(len);
        stg++;
        if (len == 0) begin
            exp_kind[exp_wr] = 1;
            exp_beat[exp_wr] = '0;
            exp_wr++;
        end
        for (int w = 0; w < nw; w++) begin
            mem[stg % MEM_N] = {8'(idx + 8'h10), 8'(w + 8'h40)};
            exp_kind[exp_wr] = 0;
            exp_beat[exp_wr] = {w == 0, w == nw - 1, (w == nw - 1) && (len % 2 == 1),
                                8'(idx + 8'h10), 8'(w + 8'h40)};
            exp_wr++;
            stg++;
        end
        while (wr_ptr < stg) begin
            @(negedge clk);
            wr_ptr = (stg - wr_ptr > chunk) ? wr_ptr + chunk : stg;
            for (int g = 0; g < GAP; g++) begin
                @(negedge clk);
                if (rmode != 0) sink_ready = ~sink_ready;
            end
        end
        @(negedge clk);
        sink_ready = 1'b1;
    endtask

    initial begin
        int snap;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(bus_oe_n && bus_rd_n && !msg_valid && !msg_len_err, "R1 in reset",
            {bus_oe_n, bus_rd_n, msg_valid, msg_len_err}, 4'b1100);
        rst = 1'b0;
        @(negedge clk);
        chk(bus_oe_n && bus_rd_n && !msg_valid && !msg_len_err, "R1 after reset",
            {bus_oe_n, bus_rd_n, msg_valid, msg_len_err}, 4'b1100);

        // Table walk: lengths, chunking (mid-message empties, R10), ready toggling (R4)
        for (int i = 0; i < N_MSG; i++)
            send_msg(i, MSG_TAB[i][0], MSG_TAB[i][1], MSG_TAB[i][2]);
        repeat (8) @(negedge clk);
        chk(rd_ptr == wr_ptr, "R5 drained", rd_ptr, wr_ptr);

        // R4: ready held low keeps words in the bridge with enable still out
        sink_ready = 1'b0;
        @(negedge clk);
        snap = rd_ptr;
        mem[stg % MEM_N] = 16'd4; stg++;
        mem[stg % MEM_N] = 16'hBEEF;
        exp_kind[exp_wr] = 0; exp_beat[exp_wr] = {3'b100, 16'hBEEF}; exp_wr++; stg++;
        mem[stg % MEM_N] = 16'hCAFE;
        exp_kind[exp_wr] = 0; exp_beat[exp_wr] = {3'b010, 16'hCAFE}; exp_wr++; stg++;
        wr_ptr = stg;
        repeat (5) @(negedge clk);
        chk(rd_ptr == snap, "R4 no pop while stalled", rd_ptr, snap);
        chk(!bus_oe_n && bus_rd_n, "R4 strobes while stalled", {bus_oe_n, bus_rd_n}, 2'b01);
        sink_ready = 1'b1;
        repeat (8) @(negedge clk);

        // R9: two zero lengths in a row, then a one-byte message
        send_msg(20, 0, 1, 0);
        send_msg(21, 0, 1, 0);
        send_msg(22, 1, 1, 0);
        repeat (8) @(negedge clk);

        // R7: every expected result delivered, none extra
        chk(exp_rd == exp_wr, "R7 result count", exp_rd, exp_wr);
        chk(bus_oe_n && bus_rd_n, "R2 idle when empty", {bus_oe_n, bus_rd_n}, 2'b11);
        report();
    end

endmodule